// File: doc/BRIEF.md
# Nested Trap Vectoring Unit

This block decides which trap a processor core takes and where the handler for that trap starts. Each cycle it samples three request sources: a vector of hardware trap lines with fixed urgency, a software trap request that carries a 6-bit trap number, and a 4-bit interrupt request level. Interrupts are filtered against a programmable interrupt mask level. Of the requests that survive, the most urgent one becomes the trap taken.

The block keeps the current nesting depth in a five-state machine with states `LVL0`, `LVL1`, `LVL2`, `LVL3` and `LVL_ERR`. It moves between them by four transitions. RAISE moves one level up when a trap is taken. LOWER moves one level down on a handler return. HOLD keeps the level when nothing happens, when a take and a return fall in the same cycle, or when a return arrives at `LVL0`. RECOVER returns to `LVL0` on reset from any state. `LVL_ERR` is level 4, the error depth. The handler address is the table base plus the trap type in 32-byte slots. Traps taken from level 0 land in the lower half of the table. Traps taken from any deeper level land in the upper half, which starts 512 slots past the base.

The chosen type and address are registered and come out with a one-cycle valid pulse. A save strobe in the same cycle tells the core to push its state before it enters the handler. The table base and the mask level are written through a small register write port.

Top module: `trap_vector_unit`

## Requirements
- R1: When several requests are present in one cycle, the one with the lowest priority value is taken. Hardware line i has value i, the software trap has value N_HW, and the interrupt has value N_HW+1.
- R2: An interrupt request of level n (1 to 15, with 0 meaning no request) is taken only when n is strictly greater than the mask level. A lower or equal level produces no trap.
- R3: Trap types are encoded as follows: hardware line i gives type 8+i, interrupt level n gives type 64+n, and software trap number k (6 bits) gives type 256+k.
- R4: The handler address is base + type*32 when the level was 0 before the trap. It is base + 16384 + type*32 when the level was 1 or more.
- R5: Each trap taken raises the level by one and each return lowers it by one. A return at level 0 is ignored. A take and a return in the same cycle leave the level unchanged, except at level 0, where the level becomes 1.
- R6: At level 4 the error output is high and no trap is taken. A return at level 4 still lowers the level to 3.
- R7: The type and the address are registered. The valid output and the save strobe pulse high for exactly one cycle, in the cycle after the clock edge that sampled the request.
- R8: A write with select 0 loads the table base with its low 5 bits forced to zero. A write with select 1 loads the mask level from data bits 3:0. A write takes effect from the next clock edge.
- R9: Reset (active low) clears the level to 0, clears the error output and the valid output, clears the base to 0, and sets the mask level to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | N_HW | Hardware trap request lines, bit 0 most urgent |
| sw_req | input | 1 | Software trap request |
| sw_num | input | 6 | Software trap number |
| irq_lvl | input | 4 | Interrupt request level, 0 = none |
| ret_req | input | 1 | Handler return, lowers the level |
| cfg_wr | input | 1 | Register write enable |
| cfg_sel | input | 1 | 0 = table base, 1 = mask level |
| cfg_wdata | input | ADDR_W | Register write data |
| vec_valid | output | 1 | One-cycle pulse: a trap was taken |
| save_stb | output | 1 | One-cycle pulse: push processor state |
| vec_type | output | 9 | Type of the trap taken |
| vec_addr | output | ADDR_W | Handler fetch address |
| trap_level | output | 3 | Current nesting level |
| level_err | output | 1 | High at level 4 |

## Verification
A trap take and a handler return can fall in the same clock edge. The result then depends on the state: at levels 1 to 3 the level must hold, at level 0 it must rise to 1, and at level 4 the return wins and the take is dropped. The bench drives `ret_req` together with a request at each of these levels and checks the level afterwards. It also checks that the address used the half selected by the level before the edge. A second overlap is a mask-level write in the same edge as an interrupt request; the bench checks that the old mask level decides that edge.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;

    localparam int TYPE_W        = 9;
    localparam int TL_W          = 3;
    localparam int SLOT_SHIFT    = 5;
    localparam int HALF_SLOTS    = 512;
    localparam int HW_TYPE_BASE  = 8;
    localparam int IRQ_TYPE_BASE = 64;
    localparam int SW_TYPE_BASE  = 256;
    localparam int SW_NUM_W      = 6;
    localparam int IRQ_W         = 4;

    typedef enum logic [2:0] {
        LVL0    = 3'd0,
        LVL1    = 3'd1,
        LVL2    = 3'd2,
        LVL3    = 3'd3,
        LVL_ERR = 3'd4
    } tl_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HW   = 2'd1,
        SRC_SW   = 2'd2,
        SRC_IRQ  = 2'd3
    } trap_src_e;

    typedef struct packed {
        logic              take;
        trap_src_e         src;
        logic [TYPE_W-1:0] ttype;
    } trap_pick_t;

endpackage

// File: rtl/trap_cfg_regs.sv
module trap_cfg_regs
    import trap_vec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base_q,
    output logic [IRQ_W-1:0]  pil_q
);

    localparam logic [IRQ_W-1:0] PIL_RESET = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            pil_q  <= PIL_RESET;
        end else if (wr_en) begin
            if (!wr_sel) begin
                base_q <= {wr_data[ADDR_W-1:SLOT_SHIFT], {SLOT_SHIFT{1'b0}}};
            end else begin
                pil_q  <= wr_data[IRQ_W-1:0];
            end
        end
    end

endmodule

// File: rtl/trap_select.sv
module trap_select
    import trap_vec_pkg::*;
#(
    parameter int N_HW = 8
) (
    input  logic [N_HW-1:0]     hw_req,
    input  logic                sw_req,
    input  logic [SW_NUM_W-1:0] sw_num,
    input  logic [IRQ_W-1:0]    irq_lvl,
    input  logic [IRQ_W-1:0]    pil,
    input  logic                block,
    output trap_pick_t          pick
);

    localparam int IDX_W = (N_HW > 1) ? $clog2(N_HW) : 1;

    logic [N_HW:0]   seen;
    logic [N_HW-1:0] first;
    logic [IDX_W-1:0] hw_idx;
    logic            hw_any;
    logic            irq_ok;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N_HW; g++) begin : g_chain
        assign first[g]  = hw_req[g] & ~seen[g];
        assign seen[g+1] = seen[g] | hw_req[g];
    end

    assign hw_any = seen[N_HW];
    assign irq_ok = (irq_lvl > pil);

    always_comb begin
        hw_idx = '0;
        for (int i = 0; i < N_HW; i++) begin
            if (first[i]) begin
                hw_idx = hw_idx | IDX_W'(i);
            end
        end
    end

    always_comb begin
        pick.take  = 1'b0;
        pick.src   = SRC_NONE;
        pick.ttype = '0;
        if (hw_any) begin
            pick.src   = SRC_HW;
            pick.ttype = TYPE_W'(HW_TYPE_BASE) + TYPE_W'(hw_idx);
        end else if (sw_req) begin
            pick.src   = SRC_SW;
            pick.ttype = TYPE_W'(SW_TYPE_BASE) + TYPE_W'(sw_num);
        end else if (irq_ok) begin
            pick.src   = SRC_IRQ;
            pick.ttype = TYPE_W'(IRQ_TYPE_BASE) + TYPE_W'(irq_lvl);
        end
        pick.take = (pick.src != SRC_NONE) && !block;
    end

    // R1: the one-hot winner of the hardware chain
    always_comb begin
        a_r1_single_hw_winner: assert ($onehot0(first));
    end

endmodule

// File: rtl/trap_level_ctl.sv
module trap_level_ctl
    import trap_vec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            ret,
    output tl_state_e       state_q,
    output logic [TL_W-1:0] tl,
    output logic            err,
    output logic            block
);

    tl_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL0: begin
                if (take) state_d = LVL1;
            end
            LVL1: begin
                if (take && !ret)      state_d = LVL2;
                else if (ret && !take) state_d = LVL0;
            end
            LVL2: begin
                if (take && !ret)      state_d = LVL3;
                else if (ret && !take) state_d = LVL1;
            end
            LVL3: begin
                if (take && !ret)      state_d = LVL_ERR;
                else if (ret && !take) state_d = LVL2;
            end
            LVL_ERR: begin
                if (ret) state_d = LVL3;
            end
            default: state_d = LVL0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL0;
        else        state_q <= state_d;
    end

    always_comb begin
        tl    = TL_W'(state_q);
        err   = (state_q == LVL_ERR);
        block = (state_q == LVL_ERR);
    end

    a_r5_raise_one: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !ret && state_q != LVL_ERR) |=> (tl == $past(tl) + 3'd1));

    a_r5_floor_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !take && state_q == LVL0) |=> (state_q == LVL0));

    a_r5_paired_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ret && state_q != LVL0 && state_q != LVL_ERR) |=> $stable(state_q));

    a_r6_err_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LVL_ERR && ret) |=> (state_q == LVL3));

endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
    import trap_vec_pkg::*;
#(
    parameter int N_HW   = 8,
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_HW-1:0]     hw_req,
    input  logic                sw_req,
    input  logic [5:0]          sw_num,
    input  logic [3:0]          irq_lvl,
    input  logic                ret_req,
    input  logic                cfg_wr,
    input  logic                cfg_sel,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic                vec_valid,
    output logic                save_stb,
    output logic [8:0]          vec_type,
    output logic [ADDR_W-1:0]   vec_addr,
    output logic [2:0]          trap_level,
    output logic                level_err
);

    localparam int OFF_W = TYPE_W + 1 + SLOT_SHIFT;

    logic [ADDR_W-1:0] base_q;
    logic [IRQ_W-1:0]  pil_q;
    trap_pick_t        pick;
    tl_state_e         lvl_state;
    logic              lvl_block;
    logic              upper_half;
    logic [OFF_W-1:0]  slot_off;
    logic [ADDR_W-1:0] addr_d;

    trap_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .base_q  (base_q),
        .pil_q   (pil_q)
    );

    trap_select #(.N_HW(N_HW)) u_sel (
        .hw_req  (hw_req),
        .sw_req  (sw_req),
        .sw_num  (sw_num),
        .irq_lvl (irq_lvl),
        .pil     (pil_q),
        .block   (lvl_block),
        .pick    (pick)
    );

    trap_level_ctl u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (pick.take),
        .ret     (ret_req),
        .state_q (lvl_state),
        .tl      (trap_level),
        .err     (level_err),
        .block   (lvl_block)
    );

    assign upper_half = (lvl_state != LVL0);
    assign slot_off   = {upper_half, pick.ttype, {SLOT_SHIFT{1'b0}}};
    assign addr_d     = base_q + ADDR_W'(slot_off);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            save_stb  <= 1'b0;
            vec_type  <= '0;
            vec_addr  <= '0;
        end else begin
            vec_valid <= pick.take;
            save_stb  <= pick.take;
            if (pick.take) begin
                vec_type <= pick.ttype;
                vec_addr <= addr_d;
            end
        end
    end

    a_r7_take_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pick.take |=> (vec_valid && save_stb));

    a_r4_slot_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[SLOT_SHIFT-1:0] == '0));

    a_r6_quiet_at_error: assert property (@(posedge clk) disable iff (!rst_n)
        level_err |=> !vec_valid);

    a_r2_irq_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (pick.take && pick.src == SRC_IRQ) |=>
            (vec_type > 9'(IRQ_TYPE_BASE) && $past(irq_lvl) > $past(pil_q)));

endmodule

// File: tb/trap_vector_unit_tb.sv
`timescale 1ns/1ps
module trap_vector_unit_tb;

    localparam int N_HW   = 8;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N_HW-1:0]   hw_req;
    logic              sw_req;
    logic [5:0]        sw_num;
    logic [3:0]        irq_lvl;
    logic              ret_req;
    logic              cfg_wr;
    logic              cfg_sel;
    logic [ADDR_W-1:0] cfg_wdata;
    logic              vec_valid;
    logic              save_stb;
    logic [8:0]        vec_type;
    logic [ADDR_W-1:0] vec_addr;
    logic [2:0]        trap_level;
    logic              level_err;

    int checks = 0;
    int fails  = 0;
    int base_m = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trap_vector_unit #(.N_HW(N_HW), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_req(sw_req),
        .sw_num(sw_num), .irq_lvl(irq_lvl), .ret_req(ret_req),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .vec_valid(vec_valid), .save_stb(save_stb), .vec_type(vec_type),
        .vec_addr(vec_addr), .trap_level(trap_level), .level_err(level_err)
    );

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        hw_req = '0; sw_req = 0; sw_num = '0; irq_lvl = '0;
        ret_req = 0; cfg_wr = 0; cfg_sel = 0; cfg_wdata = '0;
    endtask

    // one clock: inputs already driven, advance to the next falling edge, then clear
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic write_cfg(bit sel, int data);
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = data;
        tick();
    endtask

    function automatic int exp_type(int mask, bit s, int num, int lv, int pil);
        if (mask != 0) begin
            for (int i = 0; i < N_HW; i++) if (mask[i]) return 8 + i;
        end
        if (s) return 256 + num;
        if (lv > pil) return 64 + lv;
        return -1;
    endfunction

    function automatic longint exp_addr(int ty, int lvl_before);
        return longint'(base_m) + ((lvl_before != 0) ? 16384 : 0) + ty * 32;
    endfunction

    task automatic take_hw(int line, int lvl_before, string req);
        hw_req[line] = 1'b1;
        tick();
        check({req, " valid"}, vec_valid, 1);
        check({req, " type"}, vec_type, 8 + line);
        check({req, " addr"}, vec_addr, exp_addr(8 + line, lvl_before));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9 reset state
        check("R9 level", trap_level, 0);
        check("R9 err", level_err, 0);
        check("R9 valid", vec_valid, 0);
        irq_lvl = 4'd15;
        tick();
        check("R9 mask level resets to 15", vec_valid, 0);
        sw_req = 1; sw_num = 6'd0;
        tick();
        check("R9 base resets to 0", vec_addr, 256 * 32);
        ret_req = 1; tick();

        // R8 base write with low bits forced to zero
        write_cfg(0, 32'h0001_2345);
        base_m = 32'h0001_2340;
        sw_req = 1; sw_num = 6'd0;
        tick();
        check("R8 base aligned", vec_addr, 32'h0001_4340);
        ret_req = 1; tick();
        write_cfg(1, 7);

        // R1 R2 R3 R4 R7: sweep at level 0 with mask level 7
        for (int mask = 0; mask < 256; mask++) begin
            for (int s = 0; s < 2; s++) begin
                for (int lv = 0; lv < 16; lv++) begin
                    int num;
                    int ty;
                    num = (mask * 3 + lv) & 63;
                    ty  = exp_type(mask, s[0], num, lv, 7);
                    hw_req = mask[N_HW-1:0]; sw_req = s[0];
                    sw_num = 6'(num); irq_lvl = 4'(lv);
                    tick();
                    check("R1 R2 valid", vec_valid, (ty >= 0) ? 1 : 0);
                    if (ty >= 0) begin
                        check("R3 type", vec_type, ty);
                        check("R4 lower half addr", vec_addr, exp_addr(ty, 0));
                        check("R7 save strobe", save_stb, 1);
                        ret_req = 1; tick();
                        check("R7 single-cycle pulse", vec_valid, 0);
                    end
                end
            end
        end

        // R2 mask level sweep
        for (int p = 0; p < 16; p++) begin
            write_cfg(1, p);
            for (int lv = 1; lv < 16; lv++) begin
                irq_lvl = 4'(lv);
                tick();
                check("R2 mask compare", vec_valid, (lv > p) ? 1 : 0);
                if (lv > p) begin
                    check("R2 irq type", vec_type, 64 + lv);
                    ret_req = 1; tick();
                end
            end
        end

        // R2 a mask write in the same edge as an interrupt: old mask decides
        write_cfg(1, 3);
        irq_lvl = 4'd5; cfg_wr = 1; cfg_sel = 1; cfg_wdata = 9;
        tick();
        check("R2 old mask level applies", vec_valid, 1);
        ret_req = 1; tick();
        irq_lvl = 4'd5; tick();
        check("R2 new mask level applies", vec_valid, 0);

        // R4 R5 R6 nesting
        for (int l = 0; l < 4; l++) begin
            take_hw(l, l, "R4 nested");
            check("R5 raise", trap_level, l + 1);
        end
        check("R6 err at 4", level_err, 1);
        hw_req[0] = 1; tick();
        check("R6 no take at 4", vec_valid, 0);
        check("R6 level stays 4", trap_level, 4);
        hw_req[1] = 1; ret_req = 1; tick();
        check("R6 return wins at 4", vec_valid, 0);
        check("R6 level to 3", trap_level, 3);
        check("R6 err cleared", level_err, 0);
        hw_req[2] = 1; ret_req = 1; tick();
        check("R5 paired valid", vec_valid, 1);
        check("R5 paired hold", trap_level, 3);
        check("R4 paired upper addr", vec_addr, exp_addr(10, 3));
        for (int l = 3; l > 0; l--) begin
            ret_req = 1; tick();
            check("R5 lower", trap_level, l - 1);
        end
        ret_req = 1; tick();
        check("R5 return ignored at 0", trap_level, 0);
        hw_req[5] = 1; ret_req = 1; tick();
        check("R5 paired at 0 raises", trap_level, 1);
        check("R4 paired at 0 lower half", vec_addr, exp_addr(13, 0));
        sw_req = 1; sw_num = 6'd63; tick();
        check("R4 software upper half", vec_addr, exp_addr(319, 1));
        check("R5 level 2", trap_level, 2);

        // R9 reset from a deep level
        rst_n = 0; tick(); tick(); rst_n = 1;
        check("R9 level after reset", trap_level, 0);
        check("R9 valid after reset", vec_valid, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule